// File: doc/BRIEF.md
# Cumulative Distribution Sequencer

This block holds a 1024-entry, 24-bit table and walks it with an internal address counter. In accumulate operation, each entry in turn is replaced by the sum of itself and every entry at a lower address. The new value also appears on the output, so a histogram that is already in the table becomes its cumulative distribution in one pass. In table operation, the same counter loads the table one word per clock from the data input, and the old content of each entry appears on the output. While the enable is high in table operation, a pixel address indexes the table and the stored word is returned.

A pass begins when the active-low enable `run_n` is seen falling. This restarts the counter at zero and clears the running sum and the output register. Every result comes out of a three-register pipeline. The counter stops at the last address and writes no further, so one pass touches each entry exactly once. `done` reports that the last entry has been written.

Top module: `cdf_sequencer`

## Requirements
- R1: While reset is asserted and just after it, `dout` is 0 and `done` is 0.
- R2: When `run_n` is sampled low after having been sampled high, the counter restarts at address 0 and the running sum is cleared. `dout` reads 0 after that edge and after the next one.
- R3: In accumulate operation (`tbl_mode`=0), let E0 be the restart edge. The entry at address k becomes the sum of the original entries 0..k, and that sum is on `dout` after edge E(k+2).
- R4: The running sum and the stored entries are 24 bits wide and wrap modulo 2^24.
- R5: The counter holds at address 1023 once it gets there, and the entry at 1023 is processed only once. After that, `dout` repeats the stored value and the table is not written again, in either operation, until the next restart.
- R6: `done` goes to 1 on the edge that writes address 1023, which is the same edge that puts its result on `dout`. It was 0 before that edge, and a restart clears it.
- R7: If `run_n` is sampled high for an address during accumulate operation, that entry is output unchanged and is not written, and the running sum keeps its value. The counter still advances.
- R8: In table operation with `run_n` low, the word on `din` at edge E(k) is written to address k, and the previous content of address k is on `dout` after E(k+2).
- R9: In table operation with `run_n` high, a `pix_addr` sampled at an edge returns that entry on `dout` two edges later. Reads issued directly after a sequential load return the newly loaded data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_mode | input | 1 | 0 = accumulate operation, 1 = table load/lookup operation |
| run_n | input | 1 | Active-low enable; a falling edge starts a pass |
| pix_addr | input | 10 | Lookup address in table operation with the enable high |
| din | input | 24 | Word to load in table operation |
| dout | output | 24 | Registered result or read data |
| done | output | 1 | Last table entry written in the current pass |

## Verification
Each result in this block is due exactly two edges after the edge that sampled its address and enable. The bench therefore keeps the last two sampled addresses, or counts edges from the restart edge, and compares `dout` at the falling edge after the edge that is due. `done` is due on the same edge as the last sum, E1025, and it is checked one edge before that as well. The effects that the saturation and the enable-high pauses must not have are checked through later lookups of the entries involved.

// File: rtl/cdf_sequencer.sv
module cdf_sequencer #(
  parameter int AW = 10,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tbl_mode,
  input  logic          run_n,
  input  logic [AW-1:0] pix_addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          done
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic          run_q, we1, we2, sat, done_q;
  logic [AW-1:0] addr1, addr2, addr_nxt;
  logic [DW-1:0] din1, din2, rd2, acc, dout_q;
  logic          start, seq, sum_wr, fwd;
  logic [DW-1:0] wdata;

  assign start  = run_q & ~run_n;
  assign seq    = ~tbl_mode | ~run_n;
  assign sum_wr = we2 & ~tbl_mode;
  assign wdata  = tbl_mode ? din2 : rd2 + acc;
  assign fwd    = we2 && (addr2 == addr1);
  assign dout   = dout_q;
  assign done   = done_q;

  always_comb begin
    if (start)            addr_nxt = '0;
    else if (!seq)        addr_nxt = pix_addr;
    else if (addr1 == LAST) addr_nxt = LAST;
    else                  addr_nxt = addr1 + AW'(1);
  end

  always_ff @(posedge clk)
    if (we2) mem[addr2] <= wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b1;
      addr1  <= '0;
      we1    <= 1'b0;
      din1   <= '0;
      sat    <= 1'b0;
      addr2  <= '0;
      we2    <= 1'b0;
      din2   <= '0;
      rd2    <= '0;
      acc    <= '0;
      dout_q <= '0;
      done_q <= 1'b0;
    end else begin
      run_q <= run_n;
      addr1 <= addr_nxt;
      we1   <= ~run_n;
      din1  <= din;
      if (start)                    sat <= 1'b0;
      else if (seq && addr1 == LAST) sat <= 1'b1;
      addr2 <= addr1;
      we2   <= we1 & ~sat;
      din2  <= din1;
      if (start) begin
        rd2    <= '0;
        acc    <= '0;
        dout_q <= '0;
        done_q <= 1'b0;
      end else begin
        rd2    <= fwd ? wdata : mem[addr1];
        if (sum_wr) acc <= wdata;
        dout_q <= sum_wr ? wdata : rd2;
        if (we2 && addr2 == LAST) done_q <= 1'b1;
      end
    end
  end

  p_restart_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (addr1 == '0) && (acc == '0) && (dout == '0));

  p_counter_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tbl_mode && !start && addr1 != LAST) |=> (addr1 == $past(addr1) + AW'(1)));

  p_counter_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seq && !start && addr1 == LAST) |=> (addr1 == LAST));

  p_single_last_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (we2 && addr2 == LAST && !start) |=> !we2);

  p_done_after_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sat);

  p_pause_keeps_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!we2 && !start) |=> $stable(acc));
endmodule

// File: tb/tb_cdf_sequencer.sv
module tb_cdf_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_mode = 1'b1;
  logic        run_n = 1'b1;
  logic [9:0]  pix = '0;
  logic [23:0] din = '0;
  logic [23:0] dout;
  logic        done;

  int checks = 0;
  int errs = 0;
  logic [23:0] mm [1024];
  logic [23:0] hv [1024];
  logic [23:0] cv [1024];

  always #2 clk = ~clk;

  cdf_sequencer dut (
    .clk(clk), .rst_n(rst_n), .tbl_mode(tbl_mode), .run_n(run_n),
    .pix_addr(pix), .din(din), .dout(dout), .done(done)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [23:0] got, input logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  endtask

  task automatic load_table(input bit check_old);
    tbl_mode = 1'b1; run_n = 1'b1; step(); step();
    for (int k = 0; k < 1028; k++) begin
      run_n = 1'b0;
      din = (k < 1024) ? hv[k] : 24'hABCDEF;
      step();
      if (check_old && k >= 2 && k <= 1025) chk("R8 old content", dout, mm[k-2]);
    end
    for (int i = 0; i < 1024; i++) mm[i] = hv[i];
    run_n = 1'b1;
    step();
  endtask

  task automatic lookup(input int n, input string req);
    logic [9:0] h1, h2, a;
    h1 = '0; h2 = '0;
    tbl_mode = 1'b1; run_n = 1'b1;
    for (int i = 0; i < n + 2; i++) begin
      if (i == 0) a = 10'd0;
      else if (i == 1) a = 10'd1023;
      else if (i < 34) a = 10'(i - 2);
      else a = 10'($urandom % 1024);
      pix = a;
      step();
      if (i >= 2) chk((h2 == 10'd1023) ? "R5 last entry" : req, dout, mm[h2]);
      h2 = h1; h1 = a;
    end
  endtask

  task automatic accumulate();
    logic [23:0] s;
    s = '0;
    for (int i = 0; i < 1024; i++) begin s = s + mm[i]; cv[i] = s; end
    tbl_mode = 1'b0; run_n = 1'b1; step(); step();
    run_n = 1'b0;
    step();
    chk("R2 first zero", dout, 24'h0);
    chk("R6 done cleared", {23'h0, done}, 24'h0);
    step();
    chk("R2 second zero", dout, 24'h0);
    for (int k = 0; k < 1024; k++) begin
      step();
      if (k > 0 && cv[k] < cv[k-1]) chk("R4 wrapped sum", dout, cv[k]);
      else chk("R3 running sum", dout, cv[k]);
      if (k == 1022) chk("R6 done early", {23'h0, done}, 24'h0);
      if (k == 1023) chk("R6 done set", {23'h0, done}, 24'h1);
    end
    for (int j = 0; j < 3; j++) begin
      step();
      chk("R5 hold after last", dout, cv[1023]);
    end
    for (int i = 0; i < 1024; i++) mm[i] = cv[i];
    run_n = 1'b1;
    step();
  endtask

  task automatic pause_run(input int kk);
    logic [23:0] s;
    s = '0;
    tbl_mode = 1'b0; run_n = 1'b1; step(); step();
    for (int j = 0; j < kk + 24; j++) begin
      run_n = (j < kk) ? 1'b0 : 1'b1;
      step();
      if (j < 2) chk("R2 zero after restart", dout, 24'h0);
      else if (j - 2 < kk) begin
        s = s + mm[j-2];
        chk("R3 partial sum", dout, s);
        mm[j-2] = s;
      end else chk("R7 unchanged entry", dout, mm[j-2]);
    end
    chk("R6 no done on paused pass", {23'h0, done}, 24'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errs++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    step(); step();
    chk("R1 dout in reset", dout, 24'h0);
    chk("R1 done in reset", {23'h0, done}, 24'h0);
    rst_n = 1'b1;
    step();
    chk("R1 dout after reset", dout, 24'h0);
    chk("R1 done after reset", {23'h0, done}, 24'h0);

    for (int i = 0; i < 1024; i++) hv[i] = 24'($urandom % 4096);
    load_table(1'b0);
    chk("R6 done after load", {23'h0, done}, 24'h1);
    for (int i = 0; i < 1024; i++) hv[i] = 24'($urandom % (1 << 22));
    hv[0] = 24'hFFFFFF; hv[1023] = 24'h000001;
    load_table(1'b1);
    lookup(120, "R9 lookup");

    accumulate();
    lookup(80, "R3 stored sum");

    pause_run(6);
    lookup(60, "R7 paused entries");

    summary();
  end
endmodule